// File: doc/BRIEF.md
# Execute Target-Instruction Modifier

This block carries out the front half of an "execute" instruction. Given the register-number field of the execute instruction, the contents of the register that field selects, the effective address of the target and the current instruction address, it fetches the target instruction halfword by halfword over a simple request/acknowledge port. It merges the low byte of the register into the second byte of the working copy of the target. It decodes how long the target is and hands the finished, left-justified target to the execution pipeline with a one-cycle valid strobe.

Two faults are detected before anything is issued. An odd effective address raises a specification fault, and no fetch is made for it. A target whose opcode is the execute opcode itself raises an execute fault instead of being issued. The block also reports the linkage view of the instruction stream: the instruction address advanced past the 4-byte execute instruction, and that instruction's length code. A later taken-branch indication from the pipeline replaces that address.

Top module: `exec_target_mod`

## Requirements
- R1: A start with an odd `eff_addr` raises `spec_exc` for one cycle, visible one cycle after the start edge, and no halfword fetch is requested for it.
- R2: Halfwords are fetched from `eff_addr`, `eff_addr+2` and `eff_addr+4` in that order, and only as many as the decoded length needs.
- R3: With `reg_field` nonzero, bits 7:0 of the first fetched halfword (instruction bits 8-15) are ORed with `reg_val[7:0]` in the issued copy. The opcode byte is never altered.
- R4: With `reg_field` equal to zero, the issued instruction equals the fetched halfwords unchanged.
- R5: Length is decoded from opcode bits 7:6: 00 gives 2 bytes, 01 or 10 gives 4 bytes, and 11 gives 6 bytes. `tgt_len` reports the byte count. `tgt_instr` is left-justified, with the first halfword in bits 47:32 and the unused halfwords zero.
- R6: A target whose opcode is 0x44 raises `exec_exc` for one cycle after the first halfword arrives. No further fetch is made and `tgt_valid` stays low.
- R7: Every accepted start sets `next_ia` to `instr_addr+4` (modulo 2^AW) and `link_ilc` to 2. Both read 0 after reset.
- R8: A `br_taken` pulse loads `br_target` into `next_ia` on the next edge.
- R9: With a one-cycle acknowledge response, `tgt_valid` pulses for exactly one cycle, 2×(halfword count) cycles after the start edge.
- R10: A `start` while `busy` is high is ignored. The result, `next_ia` and the fetch addresses follow the first start only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an execute operation |
| reg_field | input | 4 | Register-number field of the execute instruction |
| reg_val | input | 32 | Contents of the selected register |
| eff_addr | input | AW | Effective address of the target instruction |
| instr_addr | input | AW | Address of the execute instruction |
| fetch_req | output | 1 | Halfword fetch request, held until acknowledged |
| fetch_addr | output | AW | Address of the requested halfword |
| fetch_ack | input | 1 | Fetch acknowledge; data valid in the same cycle |
| fetch_data | input | 16 | Fetched halfword |
| br_taken | input | 1 | The issued target was a taken branch |
| br_target | input | AW | Branch address for the taken branch |
| busy | output | 1 | Fetch in progress |
| tgt_valid | output | 1 | One-cycle strobe: modified target ready |
| tgt_instr | output | 48 | Modified target, left-justified |
| tgt_len | output | 3 | Target length in bytes |
| spec_exc | output | 1 | Specification fault strobe |
| exec_exc | output | 1 | Execute fault strobe |
| next_ia | output | AW | Updated instruction address for linkage |
| link_ilc | output | 2 | Instruction-length code for linkage |

## Verification
The bench's memory model acknowledges a request on the following half-cycle and then drops the acknowledge for one cycle. Each halfword therefore costs two cycles. A start gives a specification fault one cycle after its edge, an execute fault two cycles after it, and a valid target 2, 4 or 6 cycles after it. The driver stamps the cycle count at each start, and the monitor subtracts that stamp when it pops the expected item. The latency is compared exactly, together with the instruction, length, fault kind, linkage values and number of acknowledged fetches. All outputs are sampled on the falling edge.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam logic [7:0] EXEC_OPCODE    = 8'h44;
  localparam logic [1:0] EXEC_LEN_CODE  = 2'd2;
  localparam int         EXEC_LEN_BYTES = 4;

  typedef enum logic [0:0] {
    SEQ_IDLE  = 1'b0,
    SEQ_FETCH = 1'b1
  } seq_state_e;
endpackage

// File: rtl/exec_len_decode.sv
module exec_len_decode #(
  parameter int OP_W = 8,
  parameter int CNT_W = 2
) (
  input  logic [OP_W-1:0]  opcode,
  output logic [CNT_W-1:0] n_hw
);
  logic [1:0] cls;
  assign cls = opcode[OP_W-1 -: 2];

  always_comb begin
    unique case (cls)
      2'b00:   n_hw = CNT_W'(1);
      2'b11:   n_hw = CNT_W'(3);
      default: n_hw = CNT_W'(2);
    endcase
  end

  // R5
  always_comb begin
    if (!$isunknown(opcode))
      len_range_chk: assert (n_hw >= CNT_W'(1) && n_hw <= CNT_W'(3));
  end
endmodule

// File: rtl/exec_modifier.sv
module exec_modifier #(
  parameter int HW_W = 16
) (
  input  logic            merge_en,
  input  logic [7:0]      merge_byte,
  input  logic [HW_W-1:0] hw_in,
  output logic [HW_W-1:0] hw_out,
  output logic            is_exec
);
  import exec_pkg::*;

  logic [7:0] low_byte;
  assign low_byte = merge_en ? (hw_in[7:0] | merge_byte) : hw_in[7:0];
  assign hw_out   = {hw_in[HW_W-1:8], low_byte};
  assign is_exec  = (hw_out[HW_W-1 -: 8] == EXEC_OPCODE);

  // R3
  always_comb begin
    if (merge_en === 1'b1 && !$isunknown(hw_in) && !$isunknown(merge_byte))
      merge_bits_chk: assert (((hw_out[7:0] & merge_byte) == merge_byte)
                              && (hw_out[HW_W-1:8] == hw_in[HW_W-1:8]));
  end
endmodule

// File: rtl/exec_fetch_seq.sv
module exec_fetch_seq #(
  parameter int AW = 24,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [AW-1:0]    base_addr,
  input  logic             fetch_ack,
  input  logic [CNT_W-1:0] first_n_hw,
  input  logic             first_is_exec,
  output logic             fetch_req,
  output logic [AW-1:0]    fetch_addr,
  output logic             cap_en,
  output logic [CNT_W-1:0] cap_idx,
  output logic             cap_last,
  output logic             cap_exec,
  output logic             busy
);
  import exec_pkg::*;

  seq_state_e       st;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] idx_nx;

  assign idx_nx   = idx + CNT_W'(1);
  assign busy     = (st == SEQ_FETCH);
  assign cap_en   = busy && fetch_ack;
  assign cap_idx  = idx;
  assign cap_exec = cap_en && (idx == '0) && first_is_exec;
  assign cap_last = cap_en && !cap_exec &&
                    ((idx == '0) ? (first_n_hw == CNT_W'(1)) : (idx_nx == need));

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SEQ_IDLE;
      fetch_req  <= 1'b0;
      fetch_addr <= '0;
      idx        <= '0;
      need       <= '0;
    end else begin
      unique case (st)
        SEQ_IDLE: begin
          if (go) begin
            st         <= SEQ_FETCH;
            fetch_req  <= 1'b1;
            fetch_addr <= base_addr;
            idx        <= '0;
          end
        end
        SEQ_FETCH: begin
          if (fetch_ack) begin
            if (idx == '0)
              need <= first_n_hw;
            if (cap_exec || cap_last) begin
              st        <= SEQ_IDLE;
              fetch_req <= 1'b0;
            end else begin
              idx        <= idx_nx;
              fetch_addr <= fetch_addr + AW'(2);
            end
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  // R2
  idx_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && idx != '0) |-> (idx < need));

  // R2
  req_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> busy);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_en && !cap_exec && !cap_last) |=> (fetch_addr == $past(fetch_addr) + AW'(2)));
endmodule

// File: rtl/exec_target_mod.sv
module exec_target_mod #(
  parameter int AW     = 24,
  parameter int RF_W   = 4,
  parameter int REG_W  = 32,
  parameter int HW_W   = 16,
  parameter int MAX_HW = 3,
  localparam int INSTR_W = HW_W * MAX_HW,
  localparam int CNT_W   = $clog2(MAX_HW + 1),
  localparam int LEN_W   = $clog2(2 * MAX_HW + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [RF_W-1:0]    reg_field,
  input  logic [REG_W-1:0]   reg_val,
  input  logic [AW-1:0]      eff_addr,
  input  logic [AW-1:0]      instr_addr,
  output logic               fetch_req,
  output logic [AW-1:0]      fetch_addr,
  input  logic               fetch_ack,
  input  logic [HW_W-1:0]    fetch_data,
  input  logic               br_taken,
  input  logic [AW-1:0]      br_target,
  output logic               busy,
  output logic               tgt_valid,
  output logic [INSTR_W-1:0] tgt_instr,
  output logic [LEN_W-1:0]   tgt_len,
  output logic               spec_exc,
  output logic               exec_exc,
  output logic [AW-1:0]      next_ia,
  output logic [1:0]         link_ilc
);
  import exec_pkg::*;

  logic             accept;
  logic             go;
  logic             merge_q;
  logic [7:0]       merge_byte_q;
  logic [HW_W-1:0]  hw_mod;
  logic             hw_is_exec;
  logic [CNT_W-1:0] n_hw;
  logic             cap_en;
  logic [CNT_W-1:0] cap_idx;
  logic             cap_last;
  logic             cap_exec;

  assign accept = start && !busy;
  assign go     = accept && !eff_addr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      merge_q      <= 1'b0;
      merge_byte_q <= '0;
    end else if (accept) begin
      merge_q      <= (reg_field != '0);
      merge_byte_q <= reg_val[7:0];
    end
  end

  exec_modifier #(.HW_W(HW_W)) u_mod (
    .merge_en   (merge_q && (cap_idx == '0)),
    .merge_byte (merge_byte_q),
    .hw_in      (fetch_data),
    .hw_out     (hw_mod),
    .is_exec    (hw_is_exec)
  );

  exec_len_decode #(.OP_W(8), .CNT_W(CNT_W)) u_len (
    .opcode (hw_mod[HW_W-1 -: 8]),
    .n_hw   (n_hw)
  );

  exec_fetch_seq #(.AW(AW), .CNT_W(CNT_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .go            (go),
    .base_addr     (eff_addr),
    .fetch_ack     (fetch_ack),
    .first_n_hw    (n_hw),
    .first_is_exec (hw_is_exec),
    .fetch_req     (fetch_req),
    .fetch_addr    (fetch_addr),
    .cap_en        (cap_en),
    .cap_idx       (cap_idx),
    .cap_last      (cap_last),
    .cap_exec      (cap_exec),
    .busy          (busy)
  );

  genvar g;
  generate
    for (g = 0; g < MAX_HW; g++) begin : g_slot
      logic [HW_W-1:0] slot_q;
      always_ff @(posedge clk) begin
        if (rst || go)
          slot_q <= '0;
        else if (cap_en && !cap_exec && cap_idx == CNT_W'(g))
          slot_q <= hw_mod;
      end
      assign tgt_instr[INSTR_W-1-g*HW_W -: HW_W] = slot_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_valid <= 1'b0;
      spec_exc  <= 1'b0;
      exec_exc  <= 1'b0;
      tgt_len   <= '0;
    end else begin
      tgt_valid <= cap_last;
      exec_exc  <= cap_exec;
      spec_exc  <= accept && eff_addr[0];
      if (go)
        tgt_len <= '0;
      else if (cap_en && !cap_exec && cap_idx == '0)
        tgt_len <= LEN_W'(2 * n_hw);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_ia  <= '0;
      link_ilc <= '0;
    end else begin
      if (br_taken)
        next_ia <= br_target;
      else if (accept)
        next_ia <= instr_addr + AW'(EXEC_LEN_BYTES);
      if (accept)
        link_ilc <= EXEC_LEN_CODE;
    end
  end

  // R1
  spec_no_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    spec_exc |-> (!fetch_req && !busy));

  // R6
  exec_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
    exec_exc |-> (!tgt_valid && !fetch_req));

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_valid |=> !tgt_valid);

  // R8
  branch_load_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> (next_ia == $past(br_target)));

  // R10
  busy_hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !cap_en) |=> (fetch_addr == $past(fetch_addr)));
endmodule

// File: tb/exec_target_mod_tb.sv
module exec_target_mod_tb;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [3:0]    reg_field = '0;
  logic [31:0]   reg_val = '0;
  logic [AW-1:0] eff_addr = '0;
  logic [AW-1:0] instr_addr = '0;
  logic          fetch_req;
  logic [AW-1:0] fetch_addr;
  logic          fetch_ack = 1'b0;
  logic [15:0]   fetch_data = '0;
  logic          br_taken = 1'b0;
  logic [AW-1:0] br_target = '0;
  logic          busy, tgt_valid, spec_exc, exec_exc;
  logic [47:0]   tgt_instr;
  logic [2:0]    tgt_len;
  logic [AW-1:0] next_ia;
  logic [1:0]    link_ilc;

  always #2 clk = ~clk;

  exec_target_mod u_dut (
    .clk(clk), .rst(rst), .start(start), .reg_field(reg_field), .reg_val(reg_val),
    .eff_addr(eff_addr), .instr_addr(instr_addr), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
    .br_taken(br_taken), .br_target(br_target), .busy(busy), .tgt_valid(tgt_valid),
    .tgt_instr(tgt_instr), .tgt_len(tgt_len), .spec_exc(spec_exc), .exec_exc(exec_exc),
    .next_ia(next_ia), .link_ilc(link_ilc)
  );

  logic [15:0] mem [0:255];
  int cyc = 0;
  int nfetch = 0;
  int checks = 0;
  int errors = 0;
  int start_cyc = 0;
  int fetch_base = 0;

  typedef struct {
    int          kind;
    logic [47:0] instr;
    int          len;
    int          lat;
    logic [AW-1:0] nia;
    int          fetches;
    string       req;
  } exp_t;
  exp_t sb[$];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fetch_req && fetch_ack) nfetch <= nfetch + 1;
  end

  always @(negedge clk) begin
    fetch_ack  <= fetch_req && !fetch_ack;
    fetch_data <= mem[fetch_addr[8:1]];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && (tgt_valid || spec_exc || exec_exc)) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R10", "unexpected result", 64'(cyc), 64'(0));
      end else begin
        exp_t e;
        int kind;
        e = sb.pop_front();
        kind = spec_exc ? 1 : (exec_exc ? 2 : 0);
        chk(kind == e.kind, e.req, "result kind", 64'(kind), 64'(e.kind));
        chk((cyc - start_cyc) == e.lat, "R9", "latency", 64'(cyc - start_cyc), 64'(e.lat));
        chk(int'(tgt_valid) + int'(spec_exc) + int'(exec_exc) == 1, "R6", "single strobe",
            64'({tgt_valid, spec_exc, exec_exc}), 64'(0));
        chk((nfetch - fetch_base) == e.fetches, "R2", "fetch count",
            64'(nfetch - fetch_base), 64'(e.fetches));
        chk(next_ia == e.nia, "R7", "next_ia", 64'(next_ia), 64'(e.nia));
        chk(link_ilc == 2'd2, "R7", "link_ilc", 64'(link_ilc), 64'(2));
        if (e.kind == 0) begin
          chk(tgt_instr == e.instr, e.req, "tgt_instr", 64'(tgt_instr), 64'(e.instr));
          chk(int'(tgt_len) == e.len, "R5", "tgt_len", 64'(tgt_len), 64'(e.len));
        end
      end
    end
  end

  task automatic run_case(input logic [3:0] rf, input logic [31:0] rv,
                          input logic [AW-1:0] ea, input logic [AW-1:0] ia,
                          input string req, input bit poke);
    exp_t e;
    logic [15:0] h0;
    logic [7:0] op;
    int n;
    e.req = req;
    e.nia = ia + AW'(4);
    e.instr = '0;
    e.len = 0;
    h0 = mem[ea[8:1]];
    if (rf != 0) h0[7:0] = h0[7:0] | rv[7:0];
    op = h0[15:8];
    if (ea[0]) begin
      e.kind = 1; e.lat = 1; e.fetches = 0;
    end else if (op == 8'h44) begin
      e.kind = 2; e.lat = 2; e.fetches = 1;
    end else begin
      n = (op[7:6] == 2'b00) ? 1 : ((op[7:6] == 2'b11) ? 3 : 2);
      e.kind = 0; e.lat = 2 * n; e.fetches = n; e.len = 2 * n;
      e.instr[47:32] = h0;
      if (n > 1) e.instr[31:16] = mem[ea[8:1] + 8'd1];
      if (n > 2) e.instr[15:0]  = mem[ea[8:1] + 8'd2];
    end
    sb.push_back(e);
    @(negedge clk);
    reg_field = rf; reg_val = rv; eff_addr = ea; instr_addr = ia;
    start = 1'b1;
    start_cyc = cyc;
    fetch_base = nfetch;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      reg_field = 4'd7; reg_val = 32'hFF; eff_addr = 24'h40; instr_addr = 24'h999;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 40 && sb.size() != 0; i++) @(negedge clk);
    if (sb.size() != 0) begin
      chk(1'b0, req, "result timeout", 64'(sb.size()), 64'(0));
      sb.delete();
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0111 + 16'h0203);
    mem[8'h10] = 16'h1A52;
    mem[8'h20] = 16'h5A31; mem[8'h21] = 16'hBEEF;
    mem[8'h30] = 16'h9A0C; mem[8'h31] = 16'h1234;
    mem[8'h40] = 16'hD211; mem[8'h41] = 16'hCAFE; mem[8'h42] = 16'h7788;
    mem[8'h50] = 16'h4400; mem[8'h51] = 16'hAAAA;
    mem[8'h60] = 16'h0500;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !tgt_valid && !spec_exc && !exec_exc && !fetch_req, "R7", "reset outputs",
        64'({busy, tgt_valid, spec_exc, exec_exc, fetch_req}), 64'(0));
    chk(next_ia == '0 && link_ilc == 2'd0, "R7", "reset linkage",
        64'({next_ia, link_ilc}), 64'(0));

    // R3: 2-byte target with merge
    run_case(4'd3, 32'hA5A5_000F, 24'h20, 24'h001000, "R3", 1'b0);
    // R4: 4-byte target, zero register field, unchanged
    run_case(4'd0, 32'hFFFF_FFFF, 24'h40, 24'h002000, "R4", 1'b0);
    // R3: 4-byte target class 10 with merge
    run_case(4'd5, 32'h0000_00F0, 24'h60, 24'h003000, "R3", 1'b0);
    // R5: 6-byte target with merge
    run_case(4'd1, 32'h0000_0081, 24'h80, 24'hFFFFFE, "R5", 1'b0);
    // R1: odd effective address
    run_case(4'd2, 32'h0000_0001, 24'h81, 24'h004000, "R1", 1'b0);
    // R6: target is execute opcode
    run_case(4'd0, 32'h0, 24'hA0, 24'h005000, "R6", 1'b0);
    // R6: merge never turns the opcode byte into an execute
    run_case(4'd6, 32'h0000_0040, 24'hC0, 24'h005100, "R6", 1'b0);
    // R10: second start while busy ignored
    run_case(4'd4, 32'h0000_0022, 24'h80, 24'h006000, "R10", 1'b1);
    chk(next_ia == 24'h006004, "R10", "next_ia after ignored start", 64'(next_ia), 64'h006004);

    // R8: taken branch replaces next_ia
    @(negedge clk);
    br_target = 24'h00ABCD; br_taken = 1'b1;
    @(negedge clk);
    br_taken = 1'b0;
    chk(next_ia == 24'h00ABCD, "R8", "branch address", 64'(next_ia), 64'h00ABCD);
    chk(!tgt_valid && !busy, "R8", "no side effect", 64'({tgt_valid, busy}), 64'(0));

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule